// File: doc/BRIEF.md
# Texture Page-Table Miss Controller

This block services misses from a first-level texture cache against a second-level texture store that is managed like virtual memory. For each miss it takes the L2 block number and the L1 sub-block number. It adds the block number to the current texture's start register to form a page-table index, reads that entry and sorts the access into one of three cases. The access is a full hit when the block is resident and the sub-block is loaded. It is a partial hit when the block is resident but that sub-block has not been loaded yet. It is a full miss when no block is allocated. It then issues one load command, either a copy from L2 storage into L1 or a fetch from host memory into both L2 and L1, and marks the physical block as recently used in the replacement list.

On a full miss the controller asks an external victim finder for a physical block. If that block has an owner, the controller unlinks the owner's page-table entry first. It then records the new owner in a per-block back-pointer and points the entry at the block. Only the missing sub-block is fetched; the other sectors of the new block start empty. A host-triggered sweep releases every block owned by a run of table entries. The data memory and the host transfer engine sit outside the block behind command and response ports.

Top module: `tex_l2_pager`

## Requirements
- R1: After reset the block is idle (busy, vic_req, cmd_valid, act_set and act_clr low) and every page-table entry is unallocated, so the first access to any entry is a full miss.
- R2: The page-table index is cfg_start + req_blk modulo the table depth; the same block number under a different start value reaches a different entry.
- R3: A full hit issues one command with cmd_fetch=0 (copy L2 to L1) for the entry's block, pulses act_set with that block, and raises no victim request.
- R4: A partial hit issues one command with cmd_fetch=1 (host fetch into L2 and L1) for the entry's block and marks the sector loaded, so the next access to the same sector is a full hit.
- R5: A full miss holds vic_req high until vic_ack is seen, then fetches (cmd_fetch=1) into the block given on vic_blk, and that entry then maps to that block.
- R6: cmd_addr = BASE + block * BLK_BYTES + sub-block * SUB_BYTES, where block is the physical block number counted from 0.
- R7: When the victim already had an owner entry, that entry is left unallocated, so the old owner's next access is a full miss.
- R8: A newly allocated block has only the just-fetched sector marked loaded, even if its previous owner had loaded other sectors.
- R9: busy is high from the cycle after a request is accepted until cmd_done has been seen; requests presented while busy are ignored.
- R10: On flush_go while idle, entries cfg_start to cfg_start+cfg_len-1 are visited in ascending order. Each allocated entry pulses act_clr with its block on act_blk and is then left unallocated. Unallocated entries and entries outside the run are untouched.
- R11: Each serviced request produces exactly one single-cycle cmd_valid pulse, with act_set in the same cycle; when req_valid and flush_go arrive together, the request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_start | input | IDX_W | First page-table entry of the current texture |
| cfg_len | input | IDX_W+1 | Number of entries of the current texture |
| req_valid | input | 1 | L1 miss request, accepted when idle |
| req_blk | input | IDX_W | L2 block number within the texture |
| req_sub | input | SUB_W | L1 sub-block number within the L2 block |
| flush_go | input | 1 | Start a release sweep over the texture's run |
| busy | output | 1 | Controller occupied; new requests ignored |
| vic_req | output | 1 | Request a victim block |
| vic_ack | input | 1 | Victim answer valid |
| vic_blk | input | VB_W | Victim physical block number |
| cmd_valid | output | 1 | Load command pulse |
| cmd_fetch | output | 1 | 1: host fetch into L2 and L1, 0: copy L2 to L1 |
| cmd_addr | output | ADDR_W | L2 data address of the sub-block |
| cmd_pidx | output | IDX_W | Page-table index of the access |
| cmd_sub | output | SUB_W | Sub-block number of the access |
| cmd_done | input | 1 | Load command completed |
| act_set | output | 1 | Mark act_blk recently used |
| act_clr | output | 1 | Remove act_blk from the replacement list |
| act_blk | output | VB_W | Block for act_set or act_clr |

## Verification
The bench builds the block with a 16-entry table, only four physical blocks, four sub-blocks per block, 256-byte blocks, 64-byte sub-blocks and a base of 0x1000. With only four physical blocks, a victim can be handed out again after a few requests. This exercises owner eviction, reuse of a block whose old owner had loaded other sectors, and a release sweep over a run that mixes allocated and empty entries. The small sizes also make every command address easy to compute by hand, and moving the start register lets two block numbers reach one shared entry.

// File: rtl/tex_l2_pager.sv
module tex_l2_pager #(
  parameter int IDX_W = 6,
  parameter int NPHYS = 8,
  parameter int NSUB = 16,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 'h0010_0000,
  parameter int BLK_BYTES = 1024,
  parameter int SUB_BYTES = 64,
  localparam int DEPTH = 1 << IDX_W,
  localparam int VB_W = $clog2(NPHYS),
  localparam int PB_W = $clog2(NPHYS + 1),
  localparam int SUB_W = $clog2(NSUB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  cfg_start,
  input  logic [IDX_W:0]    cfg_len,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_blk,
  input  logic [SUB_W-1:0]  req_sub,
  input  logic              flush_go,
  output logic              busy,
  output logic              vic_req,
  input  logic              vic_ack,
  input  logic [VB_W-1:0]   vic_blk,
  output logic              cmd_valid,
  output logic              cmd_fetch,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [IDX_W-1:0]  cmd_pidx,
  output logic [SUB_W-1:0]  cmd_sub,
  input  logic              cmd_done,
  output logic              act_set,
  output logic              act_clr,
  output logic [VB_W-1:0]   act_blk
);
  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_VREQ, S_EVICT, S_CLAIM, S_ISSUE, S_WAIT, S_FLUSH} st_t;

  st_t st;
  logic [NSUB-1:0]  sec_q [DEPTH];
  logic [PB_W-1:0]  phy_q [DEPTH];
  logic [IDX_W:0]   own_q [NPHYS];
  logic [IDX_W-1:0] idx_q;
  logic [SUB_W-1:0] sub_q;
  logic [VB_W-1:0]  blk_q;
  logic             fetch_q;
  logic [IDX_W:0]   left_q;

  wire [PB_W-1:0]  cur_phy = phy_q[idx_q];
  wire [NSUB-1:0]  cur_sec = sec_q[idx_q];
  wire             present = cur_phy != '0;
  wire [VB_W-1:0]  phy_m1  = VB_W'(cur_phy - 1'b1);
  wire [IDX_W:0]   vic_own = own_q[blk_q];
  wire [IDX_W-1:0] own_idx = IDX_W'(vic_own - 1'b1);

  assign busy      = st != S_IDLE;
  assign vic_req   = st == S_VREQ;
  assign cmd_valid = st == S_ISSUE;
  assign act_set   = cmd_valid;
  assign act_clr   = st == S_FLUSH && left_q != '0 && present;
  assign act_blk   = act_clr ? phy_m1 : blk_q;
  assign cmd_fetch = fetch_q;
  assign cmd_pidx  = idx_q;
  assign cmd_sub   = sub_q;
  assign cmd_addr  = BASE + ADDR_W'(blk_q) * ADDR_W'(BLK_BYTES) + ADDR_W'(sub_q) * ADDR_W'(SUB_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      idx_q <= '0;
      sub_q <= '0;
      blk_q <= '0;
      fetch_q <= 1'b0;
      left_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        sec_q[i] <= '0;
        phy_q[i] <= '0;
      end
      for (int j = 0; j < NPHYS; j++) own_q[j] <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (req_valid) begin
            idx_q <= cfg_start + req_blk;
            sub_q <= req_sub;
            st <= S_LOOK;
          end else if (flush_go) begin
            idx_q <= cfg_start;
            left_q <= cfg_len;
            st <= S_FLUSH;
          end
        S_LOOK:
          if (present) begin
            blk_q <= phy_m1;
            fetch_q <= !cur_sec[sub_q];
            sec_q[idx_q][sub_q] <= 1'b1;
            st <= S_ISSUE;
          end else begin
            st <= S_VREQ;
          end
        S_VREQ:
          if (vic_ack) begin
            blk_q <= vic_blk;
            st <= S_EVICT;
          end
        S_EVICT: begin
          if (vic_own != '0) begin
            phy_q[own_idx] <= '0;
            sec_q[own_idx] <= '0;
          end
          st <= S_CLAIM;
        end
        S_CLAIM: begin
          own_q[blk_q] <= (IDX_W+1)'(idx_q) + 1'b1;
          phy_q[idx_q] <= PB_W'(blk_q) + 1'b1;
          sec_q[idx_q] <= NSUB'(1) << sub_q;
          fetch_q <= 1'b1;
          st <= S_ISSUE;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (cmd_done) st <= S_IDLE;
        S_FLUSH:
          if (left_q == '0) begin
            st <= S_IDLE;
          end else begin
            if (present) begin
              phy_q[idx_q] <= '0;
              sec_q[idx_q] <= '0;
              own_q[phy_m1] <= '0;
            end
            idx_q <= idx_q + 1'b1;
            left_q <= left_q - 1'b1;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r5_vic_hold: assert property (@(posedge clk) disable iff (!rst_n)
    vic_req && !vic_ack |=> vic_req);
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  a_r9_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_WAIT && !cmd_done |=> busy);
  a_r10_clr_alone: assert property (@(posedge clk) disable iff (!rst_n)
    act_clr |-> !cmd_valid && !vic_req && !act_set);
  a_r7_old_owner_gone: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_CLAIM && $past(st) == S_EVICT && vic_own != '0 |-> phy_q[own_idx] == '0);
  a_r4_sector_marked: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_LOOK && present |=> cur_sec[sub_q]);
endmodule

// File: tb/tex_l2_pager_test.sv
module tex_l2_pager_test;
  localparam int IW = 4, NP = 4, NS = 4, BB = 256, SB = 64;
  localparam logic [31:0] BS = 32'h1000;

  logic clk = 0, rst_n = 0;
  logic [IW-1:0] cfg_start = 2;
  logic [IW:0] cfg_len = 0;
  logic req_valid = 0, flush_go = 0, vic_ack = 0, cmd_done = 0;
  logic [IW-1:0] req_blk = 0;
  logic [1:0] req_sub = 0, vic_blk = 0;
  logic busy, vic_req, cmd_valid, cmd_fetch, act_set, act_clr;
  logic [31:0] cmd_addr;
  logic [IW-1:0] cmd_pidx;
  logic [1:0] cmd_sub, act_blk;

  tex_l2_pager #(.IDX_W(IW), .NPHYS(NP), .NSUB(NS), .ADDR_W(32), .BASE(BS),
    .BLK_BYTES(BB), .SUB_BYTES(SB)) uut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, pend = 0, vwait = 0;
  bit finished = 0;
  logic        ex_fetch[$];
  logic [31:0] ex_addr[$];
  int          ex_blk[$], vic_q[$], clr_q[$];
  string       ex_tag[$];

  task automatic chk(bit ok, string tag, string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  always @(negedge clk) begin
    cmd_done = 0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) cmd_done = 1;
    end
    if (cmd_valid) begin
      pend = 2;
      if (ex_addr.size() == 0) chk(0, "R11", "unexpected command");
      else begin
        automatic logic f = ex_fetch.pop_front();
        automatic logic [31:0] a = ex_addr.pop_front();
        automatic int b = ex_blk.pop_front();
        automatic string t = ex_tag.pop_front();
        chk(cmd_fetch == f && cmd_addr == a && act_set && act_blk == b[1:0], t,
          $sformatf("actual fetch=%0d addr=%h set=%0d blk=%0d expected fetch=%0d addr=%h set=1 blk=%0d",
            cmd_fetch, cmd_addr, act_set, act_blk, f, a, b));
      end
    end
    if (vic_ack) vic_ack = 0;
    else if (vic_req) begin
      vwait++;
      if (vwait == 3) begin
        vwait = 0;
        vic_ack = 1;
        if (vic_q.size() == 0) begin chk(0, "R3", "actual victim request expected none"); vic_blk = 0; end
        else vic_blk = vic_q.pop_front()[1:0];
      end
    end
    if (act_clr) begin
      if (clr_q.size() == 0) chk(0, "R10", $sformatf("actual clear blk=%0d expected none", act_blk));
      else begin
        automatic int e = clr_q.pop_front();
        chk(act_blk == e[1:0], "R10", $sformatf("actual clear blk=%0d expected %0d", act_blk, e));
      end
    end
  end

  task automatic access(int blk, int sub, bit fetch, bit miss, int vic, int phys, string tag, bit stray = 0);
    if (miss) vic_q.push_back(vic);
    ex_fetch.push_back(fetch);
    ex_addr.push_back(BS + 32'(phys * BB + sub * SB));
    ex_blk.push_back(phys);
    ex_tag.push_back(tag);
    while (busy) @(negedge clk);
    req_blk = blk[IW-1:0]; req_sub = sub[1:0]; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (stray) begin
      @(negedge clk);
      chk(busy, "R9", $sformatf("actual busy=%0d expected 1", busy));
      req_blk = 7; req_sub = 1; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(ex_addr.size() == 0 && vic_q.size() == 0, tag,
      $sformatf("actual pending cmds=%0d victims=%0d expected 0 0", ex_addr.size(), vic_q.size()));
  endtask

  task automatic flush(int start, int len, string tag);
    cfg_start = start[IW-1:0]; cfg_len = len[IW:0];
    flush_go = 1;
    @(negedge clk);
    flush_go = 0;
    while (busy) @(negedge clk);
    chk(clr_q.size() == 0, tag, $sformatf("actual missing clears=%0d expected 0", clr_q.size()));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !vic_req && !cmd_valid && !act_set && !act_clr, "R1",
      $sformatf("actual busy=%0d vic=%0d cmd=%0d set=%0d clr=%0d expected all 0",
        busy, vic_req, cmd_valid, act_set, act_clr));
    rst_n = 1;
    @(negedge clk);
    cfg_start = 2;
    access(0, 1, 1, 1, 2, 2, "R1 R5 R6 first miss");
    access(0, 1, 0, 0, 0, 2, "R3 full hit");
    access(0, 3, 1, 0, 0, 2, "R4 partial hit");
    access(0, 3, 0, 0, 0, 2, "R4 sector now loaded");
    access(1, 0, 1, 1, 0, 0, "R5 miss block 0");
    access(2, 2, 1, 1, 2, 2, "R9 R7 evict owner", 1);
    access(2, 3, 1, 0, 0, 2, "R8 fresh sectors");
    access(0, 1, 1, 1, 1, 1, "R7 old owner misses");
    cfg_start = 5;
    access(0, 0, 1, 1, 3, 3, "R2 start moved");
    cfg_start = 2;
    access(3, 0, 0, 0, 0, 3, "R2 shared entry hit");
    clr_q.push_back(1); clr_q.push_back(0); clr_q.push_back(2);
    flush(2, 3, "R10 sweep order");
    flush(2, 0, "R10 empty sweep");
    access(0, 1, 1, 1, 1, 1, "R10 released entry misses");
    access(3, 0, 0, 0, 0, 3, "R10 outside run kept");
    ex_fetch.push_back(1); ex_addr.push_back(BS + 32'(2 * BB + 2 * SB)); ex_blk.push_back(2);
    ex_tag.push_back("R11 request beats flush"); vic_q.push_back(2);
    req_blk = 1; req_sub = 2; req_valid = 1; flush_go = 1; cfg_len = 4;
    @(negedge clk);
    req_valid = 0; flush_go = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(ex_addr.size() == 0 && clr_q.size() == 0, "R11",
      $sformatf("actual pending=%0d expected 0", ex_addr.size()));
    finished = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !finished; c++) @(negedge clk);
    if (!finished) chk(0, "watchdog", "actual hung expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule